// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the home-side coherence engine for a small distributed shared-memory system. Each line it owns has one directory entry: a dirty flag and one presence bit per node. When the line is clean, the presence bits list the sharers. When the line is dirty, exactly one presence bit is set, and it names the owner. The block also holds a small store of line data. Requesting nodes send read-miss, write-miss and write-back messages on a request channel. The home answers on a response channel in one of three ways: with data, with the index of the node that currently holds the dirty line, or with one invalidation multicast to the exact set of sharers. It never broadcasts to all nodes.

For a dirty line, the home resolves the miss as a three-party exchange. The home tells the requester who the owner is. The owner then serves the requester directly and reports back to the home:
- A *share* message carries the line data and leaves the line clean, with both nodes as sharers.
- A *transfer* message hands ownership to the requester.

A write miss to a shared line takes these steps:
- The home sends invalidations to every sharer except the requester.
- It collects one acknowledgement from each of those sharers.
- It grants exclusive ownership only after the last acknowledgement arrives.

The controller runs one transaction at a time. The FSM has four states:
- `S_IDLE`: accepts new requests.
- `S_ACKS`: collects invalidation acknowledgements.
- `S_FWD_RD`: waits for the owner's share message.
- `S_FWD_WR`: waits for the owner's transfer message.

The transitions are:
- `S_IDLE` goes to `S_FWD_RD` on a read miss to a dirty line.
- `S_IDLE` goes to `S_FWD_WR` on a write miss to a dirty line.
- `S_IDLE` goes to `S_ACKS` on a write miss that finds other sharers.
- `S_ACKS` returns to `S_IDLE` on the last pending acknowledgement.
- `S_FWD_RD` returns to `S_IDLE` on the owner's share message.
- `S_FWD_WR` returns to `S_IDLE` on the owner's transfer message.

All other events keep the current state.

Top module: `dir_home`

## Requirements

Message codes are on `req_kind`: 0 read miss, 1 write miss, 2 write-back, 3 invalidation acknowledgement, 4 owner share (with data), 5 owner transfer.

Response codes are on `rsp_kind`: 0 data, 1 owner identity, 2 invalidate, 3 exclusive grant, 4 retry, 5 write-back acknowledgement.

`rsp_dest` bit n addresses node n. A response is registered and appears in the cycle after the request that caused it, for exactly one cycle.

- R1: After reset, every line is clean, has no presence bits and holds data zero, and `rsp_valid` is low.
- R2: A read miss to a clean line returns a data response (code 0) with the stored line to the requester only. The requester is added to the sharers.
- R3: A write miss to a clean line with no sharer other than the requester returns an exclusive grant (code 3) with data at once. The requester becomes the sole owner, and the line becomes dirty.
- R4: A write miss to a clean line with other sharers issues one invalidate (code 2). Its `rsp_dest` equals the sharer set minus the requester. The grant to the requester is issued only in the cycle after the last acknowledgement from a pending node. Acknowledgements from nodes that are not pending produce no response.
- R5: A read miss to a dirty line returns an owner-identity response (code 1), with the owner's index on `rsp_owner`, to the requester. When the owner's share message arrives, its data is stored, the line becomes clean, and owner and requester become its sharers.
- R6: A write miss to a dirty line returns an owner-identity response. When the owner's transfer message arrives, the requester becomes the line's sole dirty owner.
- R7: While a transaction is outstanding, every read miss, write miss or write-back gets a retry (code 4) addressed to its sender, and the directory is unchanged.
- R8: A write-back from the owner of a dirty line stores its data, clears the dirty flag and the owner's presence bit, and answers with code 5. A write-back from any other node is ignored: no response and no change.
- R9: A dirty line always has exactly one presence bit set.
- R10: Share or transfer messages that come from a node other than the awaited owner, or that name another line, are ignored.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Message code |
| req_node | input | NODE_W | Sending node index |
| req_line | input | LINE_W | Line index |
| req_data | input | DATA_W | Line data for write-back and share messages |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_kind | output | 3 | Response code |
| rsp_dest | output | NODES | Destination node mask |
| rsp_line | output | LINE_W | Line index of the response |
| rsp_data | output | DATA_W | Line data for data and grant responses |
| rsp_owner | output | NODE_W | Owner index for owner-identity responses |

## Verification

The bench sweeps every line, rotating the roles of three nodes, through this sequence:
1. Two reads.
2. A write that invalidates the readers.
3. A dirty read.
4. A dirty write.
5. Write-backs.

It targets these corner cases:
- **Invalidate mask.** The mask must drop the requester when the requester is itself a sharer. A design that includes it would wait forever for an acknowledgement that never comes.
- **Stray acknowledgement.** An acknowledgement from a non-pending node, arriving ahead of the real ones, must not trigger an early grant.
- **Forward from the wrong node.** A share message from a node other than the owner must not close the transaction and store stale data.
- **Write-back from a non-owner.** It must not overwrite the line.
- **Misses during an open transaction.** They must be retried, not served.

A design that mishandles any of these shows a wrong data value, destination mask or response code at the ports.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [2:0] {
        MSG_RD    = 3'd0,
        MSG_WR    = 3'd1,
        MSG_WB    = 3'd2,
        MSG_ACK   = 3'd3,
        MSG_SHARE = 3'd4,
        MSG_XFER  = 3'd5
    } msg_e;

    typedef enum logic [2:0] {
        RSP_DATA  = 3'd0,
        RSP_OWNER = 3'd1,
        RSP_INVAL = 3'd2,
        RSP_GRANT = 3'd3,
        RSP_RETRY = 3'd4,
        RSP_WBACK = 3'd5
    } rsp_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACKS   = 2'd1,
        S_FWD_RD = 2'd2,
        S_FWD_WR = 2'd3
    } home_state_e;

endpackage

// File: rtl/dir_table.sv
module dir_table #(
    parameter int LINES  = 8,
    parameter int NODES  = 4,
    parameter int DATA_W = 16,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output logic              rd_dirty,
    output logic [NODES-1:0]  rd_pres,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_dirty,
    input  logic [NODES-1:0]  wr_pres,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data
);

    logic              dirty_q [LINES];
    logic [NODES-1:0]  pres_q  [LINES];
    logic [DATA_W-1:0] data_q  [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                dirty_q[i] <= 1'b0;
                pres_q[i]  <= '0;
                data_q[i]  <= '0;
            end
        end else if (wr_en) begin
            dirty_q[wr_line] <= wr_dirty;
            pres_q[wr_line]  <= wr_pres;
            if (wr_data_en) begin
                data_q[wr_line] <= wr_data;
            end
        end
    end

    assign rd_dirty = dirty_q[rd_line];
    assign rd_pres  = pres_q[rd_line];
    assign rd_data  = data_q[rd_line];

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_own_chk
            // R9: a dirty entry names exactly one owner
            a_r9_dirty_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
                dirty_q[g] |-> $onehot(pres_q[g]));
        end
    endgenerate

endmodule

// File: rtl/dir_acks.sv
module dir_acks #(
    parameter int NODES = 4,
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NODES-1:0]  load_mask,
    input  logic              ack_valid,
    input  logic [NODE_W-1:0] ack_node,
    output logic [NODES-1:0]  pending
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (load) begin
            pending <= load_mask;
        end else if (ack_valid) begin
            pending <= pending & ~(NODES'(1) << ack_node);
        end
    end

    // R4: outside a load the set of awaited nodes only shrinks
    a_r4_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (pending & ~$past(pending)) == '0);

    // R4: only one acknowledgement retires per cycle
    a_r4_one_ack_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $countones($past(pending) & ~pending) <= 1);

endmodule

// File: rtl/dir_home.sv
module dir_home
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int LINES  = 8,
    parameter int DATA_W = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [NODE_W-1:0] req_node,
    input  logic [LINE_W-1:0] req_line,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic [NODES-1:0]  rsp_dest,
    output logic [LINE_W-1:0] rsp_line,
    output logic [DATA_W-1:0] rsp_data,
    output logic [NODE_W-1:0] rsp_owner
);

    home_state_e       state, nstate;
    logic [LINE_W-1:0] cur_line, ncur_line;
    logic [NODE_W-1:0] cur_node, ncur_node;
    logic [NODE_W-1:0] cur_owner, ncur_owner;

    logic              t_dirty;
    logic [NODES-1:0]  t_pres;
    logic [DATA_W-1:0] t_data;
    logic [LINE_W-1:0] t_rd_line;
    logic              w_en, w_dirty, w_data_en;
    logic [NODES-1:0]  w_pres;
    logic [DATA_W-1:0] w_data;

    logic              a_load, a_ack;
    logic [NODES-1:0]  a_mask, pending;

    logic              n_valid;
    rsp_e              n_kind;
    logic [NODES-1:0]  n_dest;
    logic [DATA_W-1:0] n_data;
    logic [NODE_W-1:0] n_owner;

    msg_e              kind;
    logic [NODES-1:0]  req_bit, cur_bit, others;
    logic [NODE_W-1:0] owner_idx;
    logic              is_miss_or_wb;

    assign kind          = msg_e'(req_kind);
    assign req_bit       = NODES'(1) << req_node;
    assign cur_bit       = NODES'(1) << cur_node;
    assign t_rd_line     = (state == S_IDLE) ? req_line : cur_line;
    assign others        = t_pres & ~req_bit;
    assign is_miss_or_wb = (kind == MSG_RD) || (kind == MSG_WR) || (kind == MSG_WB);

    always_comb begin
        owner_idx = '0;
        for (int i = 0; i < NODES; i++) begin
            if (t_pres[i]) owner_idx = NODE_W'(i);
        end
    end

    dir_table #(.LINES(LINES), .NODES(NODES), .DATA_W(DATA_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_line(t_rd_line), .rd_dirty(t_dirty), .rd_pres(t_pres), .rd_data(t_data),
        .wr_en(w_en), .wr_line(t_rd_line), .wr_dirty(w_dirty), .wr_pres(w_pres),
        .wr_data_en(w_data_en), .wr_data(w_data)
    );

    dir_acks #(.NODES(NODES)) u_acks (
        .clk(clk), .rst_n(rst_n),
        .load(a_load), .load_mask(a_mask),
        .ack_valid(a_ack), .ack_node(req_node),
        .pending(pending)
    );

    always_comb begin
        nstate     = state;
        ncur_line  = cur_line;
        ncur_node  = cur_node;
        ncur_owner = cur_owner;
        w_en       = 1'b0;
        w_dirty    = t_dirty;
        w_pres     = t_pres;
        w_data_en  = 1'b0;
        w_data     = req_data;
        a_load     = 1'b0;
        a_mask     = others;
        a_ack      = 1'b0;
        n_valid    = 1'b0;
        n_kind     = RSP_DATA;
        n_dest     = req_bit;
        n_data     = t_data;
        n_owner    = '0;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    ncur_line  = req_line;
                    ncur_node  = req_node;
                    ncur_owner = owner_idx;
                    unique case (kind)
                        MSG_RD: begin
                            n_valid = 1'b1;
                            if (t_dirty) begin
                                n_kind  = RSP_OWNER;
                                n_owner = owner_idx;
                                nstate  = S_FWD_RD;
                            end else begin
                                n_kind = RSP_DATA;
                                w_en   = 1'b1;
                                w_pres = t_pres | req_bit;
                            end
                        end
                        MSG_WR: begin
                            n_valid = 1'b1;
                            if (t_dirty) begin
                                n_kind  = RSP_OWNER;
                                n_owner = owner_idx;
                                nstate  = S_FWD_WR;
                            end else if (others == '0) begin
                                n_kind  = RSP_GRANT;
                                w_en    = 1'b1;
                                w_dirty = 1'b1;
                                w_pres  = req_bit;
                            end else begin
                                n_kind = RSP_INVAL;
                                n_dest = others;
                                a_load = 1'b1;
                                nstate = S_ACKS;
                            end
                        end
                        MSG_WB: begin
                            if (t_dirty && t_pres == req_bit) begin
                                n_valid   = 1'b1;
                                n_kind    = RSP_WBACK;
                                w_en      = 1'b1;
                                w_dirty   = 1'b0;
                                w_pres    = '0;
                                w_data_en = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_ACKS: begin
                if (req_valid && kind == MSG_ACK && req_line == cur_line && pending[req_node]) begin
                    a_ack = 1'b1;
                    if ((pending & ~req_bit) == '0) begin
                        n_valid = 1'b1;
                        n_kind  = RSP_GRANT;
                        n_dest  = cur_bit;
                        w_en    = 1'b1;
                        w_dirty = 1'b1;
                        w_pres  = cur_bit;
                        nstate  = S_IDLE;
                    end
                end
            end
            S_FWD_RD: begin
                if (req_valid && kind == MSG_SHARE && req_line == cur_line && req_node == cur_owner) begin
                    w_en      = 1'b1;
                    w_dirty   = 1'b0;
                    w_pres    = t_pres | cur_bit;
                    w_data_en = 1'b1;
                    nstate    = S_IDLE;
                end
            end
            S_FWD_WR: begin
                if (req_valid && kind == MSG_XFER && req_line == cur_line && req_node == cur_owner) begin
                    w_en    = 1'b1;
                    w_dirty = 1'b1;
                    w_pres  = cur_bit;
                    nstate  = S_IDLE;
                end
            end
        endcase
        if (state != S_IDLE && req_valid && is_miss_or_wb) begin
            n_valid = 1'b1;
            n_kind  = RSP_RETRY;
            n_dest  = req_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cur_line  <= '0;
            cur_node  <= '0;
            cur_owner <= '0;
        end else begin
            state     <= nstate;
            cur_line  <= ncur_line;
            cur_node  <= ncur_node;
            cur_owner <= ncur_owner;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= 3'd0;
            rsp_dest  <= '0;
            rsp_line  <= '0;
            rsp_data  <= '0;
            rsp_owner <= '0;
        end else begin
            rsp_valid <= n_valid;
            rsp_kind  <= n_kind;
            rsp_dest  <= n_dest;
            rsp_line  <= (state == S_IDLE) ? req_line : ((n_kind == RSP_RETRY) ? req_line : cur_line);
            rsp_data  <= n_data;
            rsp_owner <= n_owner;
        end
    end

    // R7: a miss or write-back during an open transaction is bounced
    a_r7_retry_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && req_valid && is_miss_or_wb) |=> (rsp_valid && rsp_kind == RSP_RETRY));

    // R4: exclusive grant never precedes the last acknowledgement
    a_r4_grant_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RSP_GRANT) |-> pending == '0);

    // R2: every response other than invalidate goes to exactly one node
    a_r2_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != RSP_INVAL) |-> $onehot(rsp_dest));

    // R4: an invalidate is never addressed to an empty set
    a_r4_inval_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RSP_INVAL) |-> rsp_dest != '0);

    // R6: a transaction opened by a miss leaves the idle state
    a_r6_busy_after_dirty_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RSP_OWNER) |-> state != S_IDLE);

endmodule

// File: tb/dir_home_test.sv
`timescale 1ns/1ps
module dir_home_test;

    localparam int NODES = 4;
    localparam int LINES = 8;
    localparam int DW    = 16;

    localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_WB = 3'd2, K_ACK = 3'd3, K_SHARE = 3'd4, K_XFER = 3'd5;
    localparam logic [2:0] P_DATA = 3'd0, P_OWNER = 3'd1, P_INVAL = 3'd2, P_GRANT = 3'd3, P_RETRY = 3'd4, P_WBACK = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_kind = '0;
    logic [1:0]    req_node = '0;
    logic [2:0]    req_line = '0;
    logic [DW-1:0] req_data = '0;
    logic          rsp_valid;
    logic [2:0]    rsp_kind;
    logic [3:0]    rsp_dest;
    logic [2:0]    rsp_line;
    logic [DW-1:0] rsp_data;
    logic [1:0]    rsp_owner;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dir_home #(.NODES(NODES), .LINES(LINES), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_node(req_node),
        .req_line(req_line), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dest(rsp_dest),
        .rsp_line(rsp_line), .rsp_data(rsp_data), .rsp_owner(rsp_owner)
    );

    task automatic send(input logic [2:0] k, input int n, input int l, input logic [DW-1:0] d);
        req_valid = 1'b1;
        req_kind  = k;
        req_node  = n[1:0];
        req_line  = l[2:0];
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_none(input string tag);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: rsp_valid=%0b kind=%0d expected no response", tag, rsp_valid, rsp_kind);
        end
    endtask

    task automatic expect_rsp(input string tag, input logic [2:0] k, input logic [3:0] dest,
                              input int l, input logic chk_data, input logic [DW-1:0] d,
                              input logic chk_own, input logic [1:0] own);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_kind !== k || rsp_dest !== dest || rsp_line !== l[2:0] ||
            (chk_data && rsp_data !== d) || (chk_own && rsp_owner !== own)) begin
            errors++;
            $display("FAIL %s: valid=%0b kind=%0d dest=%b line=%0d data=%h owner=%0d expected kind=%0d dest=%b line=%0d data=%h owner=%0d",
                     tag, rsp_valid, rsp_kind, rsp_dest, rsp_line, rsp_data, rsp_owner,
                     k, dest, l, d, own);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_none("R1 reset idle");
        for (int l = 0; l < LINES; l++) begin
            automatic int a = l % NODES;
            automatic int b = (l + 1) % NODES;
            automatic int c = (l + 2) % NODES;
            automatic logic [3:0] ba = 4'(1 << a);
            automatic logic [3:0] bb = 4'(1 << b);
            automatic logic [3:0] bc = 4'(1 << c);
            automatic logic [DW-1:0] d1 = DW'(l * 37 + 5);
            automatic logic [DW-1:0] d2 = DW'(l * 91 + 3);
            automatic logic [DW-1:0] d3 = DW'(16'hA000 + l);

            send(K_ACK, a, l, '0);       expect_none("R4 ack while idle ignored");
            send(K_RD, a, l, '0);        expect_rsp("R1 R2 read clean reset data", P_DATA, ba, l, 1, '0, 0, '0);
            send(K_RD, b, l, '0);        expect_rsp("R2 second reader", P_DATA, bb, l, 1, '0, 0, '0);
            send(K_WR, c, l, '0);        expect_rsp("R4 inval sharers", P_INVAL, ba | bb, l, 0, '0, 0, '0);
            send(K_RD, a, l, '0);        expect_rsp("R7 retry read", P_RETRY, ba, l, 0, '0, 0, '0);
            send(K_WB, b, l, 16'h1234);  expect_rsp("R7 retry writeback", P_RETRY, bb, l, 0, '0, 0, '0);
            send(K_ACK, c, l, '0);       expect_none("R4 stray ack ignored");
            send(K_ACK, a, l, '0);       expect_none("R4 partial ack");
            send(K_ACK, b, l, '0);       expect_rsp("R4 grant after last ack", P_GRANT, bc, l, 1, '0, 0, '0);
            send(K_RD, a, l, '0);        expect_rsp("R5 owner id", P_OWNER, ba, l, 0, '0, 1, 2'(c));
            send(K_SHARE, b, l, 16'hDEAD); expect_none("R10 share from wrong node");
            send(K_SHARE, c, (l + 1) % LINES, 16'hBEEF); expect_none("R10 share for wrong line");
            send(K_SHARE, c, l, d1);     expect_none("R5 share accepted");
            send(K_RD, b, l, '0);        expect_rsp("R5 data stored clean", P_DATA, bb, l, 1, d1, 0, '0);
            send(K_WR, b, l, '0);        expect_rsp("R4 inval excludes requester", P_INVAL, ba | bc, l, 0, '0, 0, '0);
            send(K_ACK, a, l, '0);       expect_none("R4 first ack");
            send(K_ACK, c, l, '0);       expect_rsp("R4 grant to sharer-requester", P_GRANT, bb, l, 1, d1, 0, '0);
            send(K_WR, a, l, '0);        expect_rsp("R6 owner id on write", P_OWNER, ba, l, 0, '0, 1, 2'(b));
            send(K_XFER, c, l, '0);      expect_none("R10 transfer from wrong node");
            send(K_XFER, b, l, '0);      expect_none("R6 transfer accepted");
            send(K_RD, c, l, '0);        expect_rsp("R6 new owner reported", P_OWNER, bc, l, 0, '0, 1, 2'(a));
            send(K_SHARE, a, l, d1);     expect_none("R5 share closes");
            send(K_WR, a, l, '0);        expect_rsp("R4 inval reader", P_INVAL, bc, l, 0, '0, 0, '0);
            send(K_ACK, c, l, '0);       expect_rsp("R4 regrant", P_GRANT, ba, l, 1, d1, 0, '0);
            send(K_WB, c, l, 16'h0999);  expect_none("R8 non-owner writeback ignored");
            send(K_WB, a, l, d2);        expect_rsp("R8 owner writeback", P_WBACK, ba, l, 0, '0, 0, '0);
            send(K_RD, c, l, '0);        expect_rsp("R8 writeback data stored", P_DATA, bc, l, 1, d2, 0, '0);
            send(K_WR, c, l, '0);        expect_rsp("R3 sole sharer grant", P_GRANT, bc, l, 1, d2, 0, '0);
            send(K_WB, c, l, d3);        expect_rsp("R8 writeback", P_WBACK, bc, l, 0, '0, 0, '0);
            send(K_WR, b, l, '0);        expect_rsp("R3 R8 empty line grant", P_GRANT, bb, l, 1, d3, 0, '0);
            send(K_WB, b, l, d3);        expect_rsp("R9 owner cleared", P_WBACK, bb, l, 0, '0, 0, '0);
            @(negedge clk);              expect_none("R1 quiet cycle");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule